// File: doc/BRIEF.md
# Page-Write Buffer and Write Engine

This block models the write path of a byte-wide nonvolatile memory that programs a whole page at a time. The host drives active-low chip-enable, write-enable and output-enable lines. A write strobe exists while both chip enable and write enable are low. When the strobe becomes active the block takes the address, and when it is released it takes the data. Up to one page of bytes is gathered in a buffer. Once the strobe has stayed inactive for a programmable quiet time, the buffered bytes are committed to the array in one internal programming cycle of fixed length. All limits are given in clock cycles, so simulation can use short values.

From the first accepted strobe until programming ends, the block is busy. It pulls its open-drain ready/busy line low, ignores any load once programming has begun, and answers reads with a status byte instead of array data. In that byte the top bit is the inverse of the top bit of the last byte loaded, and bit 6 flips on every read. A separate active-low guard input blocks all reads and writes. Taking it low during loading or programming abandons the cycle and writes nothing.

The controller has three states. ST_IDLE moves to ST_LOAD when a write strobe becomes active (open). ST_LOAD moves to ST_PROG when the quiet time has run out after the last data latch (close). ST_PROG returns to ST_IDLE when the programming count ends (done). ST_LOAD and ST_PROG both return to ST_IDLE when the guard input goes low (abort). The array is a small register memory of ARR_PAGE_W page bits. Pages whose low page-address bits match share storage.

Top module: `pgwr_engine`

## Requirements
- R1: The write strobe is active while ce_n and we_n are both low, whichever falls first; the address is sampled in the first cycle of the strobe and the data in the first cycle after it ends, so later changes of addr during the strobe or of wdata before its end have no effect.
- R2: The page (addr[12:6]) is taken from the first load of a cycle; every later load of that cycle uses only its addr[5:0] as the byte offset and is written into the first load's page.
- R3: Outside a write cycle a read returns the array byte at addr[ARR_PAGE_W+5:0] (default addr[7:0], so pages alias modulo 4); byte positions of a page not loaded in a cycle keep their previous contents; the array is all zero after reset.
- R4: A load is accepted only if its strobe starts fewer than WIN_CYC cycles after the start of the previous accepted strobe; a later one is ignored (not stored) but still counts as strobe activity.
- R5: Programming starts once the strobe has been inactive for CLOSE_CYC consecutive cycles after the last data latch, lasts PROG_CYC cycles and updates the array only at its end; loads during programming are ignored.
- R6: While busy, a read returns bit 7 as the complement of bit 7 of the last byte loaded and bits 5:0 as zero.
- R7: While busy, bit 6 of the read byte is 1 on the first read of a write cycle and flips on each further read.
- R8: rb_pull (1 = line driven low, 0 = released) is 0 when idle, becomes 1 in the cycle after the first strobe of a cycle, and returns to 0 the cycle after programming ends.
- R9: While guard_n is low no strobe or read is recognised; guard_n low during loading or programming returns the block to idle with rb_pull released and nothing written.
- R10: A read starts when ce_n and oe_n are low and we_n high; rdata is updated and rdata_vld is 1 from the cycle after the read starts, and rdata_vld follows the read condition one cycle late.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| guard_n | input | 1 | Active-low inhibit of all reads and writes, aborts a write cycle |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (13) | Byte address |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data or busy status |
| rdata_vld | output | 1 | Read data valid |
| rb_pull | output | 1 | Open-drain ready/busy enable, 1 drives the line low |

## Verification
Three cases are hard to reach from the pins. The first is a load that arrives during programming. The bench stays idle for longer than the quiet time and shorter than the quiet time plus the programming time, and only then strobes. The second is a load that falls outside the acceptance window but inside the quiet window. It is placed in the gap between WIN_CYC and CLOSE_CYC, which the shortened limits make wide. The third is an abort during programming. Guard is dropped at a cycle count known to fall inside ST_PROG, and a read-back afterwards shows the location untouched.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pgwr_state_e;

endpackage

// File: rtl/pgwr_edges.sv
// Strobe qualification and edge detection for the write and read strobes.
module pgwr_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic guard_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_act,
    output logic wr_fall,
    output logic wr_rise,
    output logic rd_act,
    output logic rd_start
);

    logic wr_act_q;
    logic rd_act_q;

    assign wr_act   = ~ce_n & ~we_n & guard_n;
    assign rd_act   = ~ce_n & ~oe_n & we_n & guard_n;
    assign wr_fall  = wr_act & ~wr_act_q;
    assign wr_rise  = ~wr_act & wr_act_q;
    assign rd_start = rd_act & ~rd_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
        end
    end

endmodule

// File: rtl/pgwr_ctrl.sv
// Write-cycle controller: load window, quiet timer, programming timer.
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int OFS_W     = 6,
    parameter int WIN_CYC   = 6000,
    parameter int CLOSE_CYC = 20000,
    parameter int PROG_CYC  = 2000000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      guard_n,
    input  logic                      wr_act,
    input  logic                      wr_fall,
    input  logic                      wr_rise,
    input  logic                      rd_start,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         wdata,
    output logic                      busy,
    output logic                      prog_now,
    output logic                      ld_en,
    output logic                      buf_clr,
    output logic                      commit,
    output logic [ADDR_W-OFS_W-1:0]   page_q,
    output logic [OFS_W-1:0]          ofs_q,
    output logic [DATA_W-1:0]         last_q,
    output logic                      tog_q
);

    localparam int WW = $clog2(WIN_CYC + 1);
    localparam int QW = $clog2(CLOSE_CYC + 1);
    localparam int PW = $clog2(PROG_CYC + 1);
    localparam logic [WW-1:0] WIN_LIM    = WW'(WIN_CYC);
    localparam logic [QW-1:0] CLOSE_LAST = QW'(CLOSE_CYC - 1);
    localparam logic [PW-1:0] PROG_LAST  = PW'(PROG_CYC - 1);

    pgwr_state_e state_q, state_d;

    logic [WW-1:0] win_q;
    logic [QW-1:0] quiet_q;
    logic [PW-1:0] prog_q;
    logic          acc_q;
    logic          had_q;
    logic          win_ok;
    logic          close_hit;
    logic          prog_done;

    assign win_ok    = (win_q < WIN_LIM);
    assign close_hit = had_q && !wr_act && !(wr_rise && acc_q) && (quiet_q == CLOSE_LAST);
    assign prog_done = (prog_q == PROG_LAST);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (wr_fall) state_d = ST_LOAD;
            ST_LOAD: begin
                if (!guard_n)       state_d = ST_IDLE;
                else if (close_hit) state_d = ST_PROG;
            end
            ST_PROG: if (!guard_n || prog_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state register
    always_comb begin
        busy     = (state_q != ST_IDLE);
        prog_now = (state_q == ST_PROG);
        ld_en    = (state_q == ST_LOAD) && guard_n && wr_rise && acc_q;
        commit   = (state_q == ST_PROG) && guard_n && prog_done;
        buf_clr  = ((state_q == ST_IDLE) && wr_fall) || (busy && !guard_n) || commit;
    end

    // timers and captured fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q  <= '0;
            ofs_q   <= '0;
            last_q  <= '0;
            tog_q   <= 1'b0;
            acc_q   <= 1'b0;
            had_q   <= 1'b0;
            win_q   <= '0;
            quiet_q <= '0;
            prog_q  <= '0;
        end else begin
            if (rd_start && busy) tog_q <= ~tog_q;
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_fall) begin
                        page_q  <= addr[ADDR_W-1:OFS_W];
                        ofs_q   <= addr[OFS_W-1:0];
                        acc_q   <= 1'b1;
                        had_q   <= 1'b0;
                        win_q   <= '0;
                        quiet_q <= '0;
                        tog_q   <= 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (guard_n) begin
                        if (wr_fall) begin
                            if (win_ok) begin
                                ofs_q <= addr[OFS_W-1:0];
                                acc_q <= 1'b1;
                                win_q <= '0;
                            end else begin
                                acc_q <= 1'b0;
                            end
                        end else if (win_ok) begin
                            win_q <= win_q + WW'(1);
                        end
                        if (wr_rise && acc_q) begin
                            last_q  <= wdata;
                            had_q   <= 1'b1;
                            acc_q   <= 1'b0;
                            quiet_q <= '0;
                        end else if (wr_act) begin
                            quiet_q <= '0;
                        end else if (had_q && !close_hit) begin
                            quiet_q <= quiet_q + QW'(1);
                        end
                        if (close_hit) prog_q <= '0;
                    end
                end
                ST_PROG: prog_q <= prog_q + PW'(1);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pgwr_pagebuf.sv
// One page of byte slots with a loaded flag per slot.
module pgwr_pagebuf #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          ld_en,
    input  logic [OFS_W-1:0]              ofs,
    input  logic [DATA_W-1:0]             din,
    output logic [(1<<OFS_W)-1:0]         valid,
    output logic [(1<<OFS_W)*DATA_W-1:0]  slots_flat
);

    localparam int DEPTH = 1 << OFS_W;

    logic [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            if (clr) valid <= '0;
            if (ld_en) begin
                slot_q[ofs] <= din;
                valid[ofs]  <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign slots_flat[g*DATA_W +: DATA_W] = slot_q[g];
    end

endmodule

// File: rtl/pgwr_array.sv
// Register array: whole-page commit of loaded slots, asynchronous read.
module pgwr_array #(
    parameter int DATA_W     = 8,
    parameter int OFS_W      = 6,
    parameter int ARR_PAGE_W = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [ARR_PAGE_W-1:0]         page,
    input  logic [(1<<OFS_W)-1:0]         valid,
    input  logic [(1<<OFS_W)*DATA_W-1:0]  slots_flat,
    input  logic [ARR_PAGE_W+OFS_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]             rd_byte
);

    localparam int PG    = 1 << OFS_W;
    localparam int DEPTH = 1 << (ARR_PAGE_W + OFS_W);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            for (int i = 0; i < PG; i++) begin
                if (valid[i]) mem[{page, OFS_W'(i)}] <= slots_flat[i*DATA_W +: DATA_W];
            end
        end
    end

    assign rd_byte = mem[rd_addr];

endmodule

// File: rtl/pgwr_engine.sv
// Top: page-write buffer and write engine.
module pgwr_engine
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int OFS_W      = 6,
    parameter int ARR_PAGE_W = 2,
    parameter int WIN_CYC    = 6000,
    parameter int CLOSE_CYC  = 20000,
    parameter int PROG_CYC   = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld,
    output logic              rb_pull
);

    localparam int PAGE_W   = ADDR_W - OFS_W;
    localparam int PG_BYTES = 1 << OFS_W;
    localparam int ARR_W    = ARR_PAGE_W + OFS_W;

    logic wr_act, wr_fall, wr_rise, rd_act, rd_start;
    logic busy, prog_now, ld_en, buf_clr, commit;
    logic [PAGE_W-1:0]          page_q;
    logic [OFS_W-1:0]           ofs_q;
    logic [DATA_W-1:0]          last_q;
    logic                       tog_q;
    logic [PG_BYTES-1:0]        pb_valid;
    logic [PG_BYTES*DATA_W-1:0] pb_slots;
    logic [DATA_W-1:0]          arr_byte;
    logic [DATA_W-1:0]          poll_byte;

    pgwr_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .guard_n  (guard_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .wr_act   (wr_act),
        .wr_fall  (wr_fall),
        .wr_rise  (wr_rise),
        .rd_act   (rd_act),
        .rd_start (rd_start)
    );

    pgwr_ctrl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .OFS_W     (OFS_W),
        .WIN_CYC   (WIN_CYC),
        .CLOSE_CYC (CLOSE_CYC),
        .PROG_CYC  (PROG_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .guard_n  (guard_n),
        .wr_act   (wr_act),
        .wr_fall  (wr_fall),
        .wr_rise  (wr_rise),
        .rd_start (rd_start),
        .addr     (addr),
        .wdata    (wdata),
        .busy     (busy),
        .prog_now (prog_now),
        .ld_en    (ld_en),
        .buf_clr  (buf_clr),
        .commit   (commit),
        .page_q   (page_q),
        .ofs_q    (ofs_q),
        .last_q   (last_q),
        .tog_q    (tog_q)
    );

    pgwr_pagebuf #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (buf_clr),
        .ld_en      (ld_en),
        .ofs        (ofs_q),
        .din        (wdata),
        .valid      (pb_valid),
        .slots_flat (pb_slots)
    );

    pgwr_array #(
        .DATA_W     (DATA_W),
        .OFS_W      (OFS_W),
        .ARR_PAGE_W (ARR_PAGE_W)
    ) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .page       (page_q[ARR_PAGE_W-1:0]),
        .valid      (pb_valid),
        .slots_flat (pb_slots),
        .rd_addr    (addr[ARR_W-1:0]),
        .rd_byte    (arr_byte)
    );

    if (ARR_PAGE_W < PAGE_W) begin : g_alias
        logic unused_page_hi;
        assign unused_page_hi = ^page_q[PAGE_W-1:ARR_PAGE_W];
    end

    assign poll_byte = {~last_q[DATA_W-1], tog_q, {(DATA_W-2){1'b0}}};
    assign rb_pull   = busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else begin
            rdata_vld <= rd_act;
            if (rd_start) rdata <= busy ? poll_byte : arr_byte;
        end
    end

endmodule

// File: rtl/pgwr_engine_chk.sv
// Property checker, attached to the top by bind.
module pgwr_engine_chk #(
    parameter int DATA_W   = 8,
    parameter int PG_BYTES = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                guard_n,
    input logic                ce_n,
    input logic                we_n,
    input logic                rdata_vld,
    input logic [DATA_W-1:0]   rdata,
    input logic                rb_pull,
    input logic                busy,
    input logic                prog_now,
    input logic                commit,
    input logic [DATA_W-1:0]   last_q,
    input logic [PG_BYTES-1:0] pb_valid
);

    assert_guard_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !guard_n |=> !rb_pull);

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_pull) |-> $past(!ce_n && !we_n));

    assert_read_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |-> $past(guard_n));

    assert_commit_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !rb_pull);

    assert_load_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_now && guard_n && !commit) |=> $stable(pb_valid));

    assert_poll_bit7_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdata_vld) && $past(busy)) |-> (rdata[DATA_W-1] == ~$past(last_q[DATA_W-1])));

endmodule

bind pgwr_engine pgwr_engine_chk #(
    .DATA_W   (DATA_W),
    .PG_BYTES (PG_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .guard_n   (guard_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .rdata_vld (rdata_vld),
    .rdata     (rdata),
    .rb_pull   (rb_pull),
    .busy      (busy),
    .prog_now  (prog_now),
    .commit    (commit),
    .last_q    (last_q),
    .pb_valid  (pb_valid)
);

// File: tb/pgwr_engine_test.sv
`timescale 1ns/1ps
module pgwr_engine_test;

    localparam int WIN  = 12;
    localparam int CLS  = 20;
    localparam int PRG  = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        guard_n = 1'b1;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_vld;
    logic        rb_pull;

    int ncmp = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pgwr_engine #(
        .WIN_CYC   (WIN),
        .CLOSE_CYC (CLS),
        .PROG_CYC  (PRG)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .guard_n   (guard_n),
        .ce_n      (ce_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .rdata_vld (rdata_vld),
        .rb_pull   (rb_pull)
    );

    // ---------------- behavioural reference model ----------------
    int       m_st;          // 0 idle, 1 loading, 2 programming
    int       m_page, m_idx, m_wc, m_qc, m_pc;
    bit       m_acc, m_had, m_tog, m_wq, m_rq, m_vld, m_poll;
    bit [7:0] m_last, m_rdata;
    bit [7:0] m_arr [256];
    bit [7:0] m_pb  [64];
    bit       m_pv  [64];

    always @(posedge clk) begin : model
        bit w, r, fa, ri, rs;
        if (!rst_n) begin
            m_st = 0; m_page = 0; m_idx = 0; m_wc = 0; m_qc = 0; m_pc = 0;
            m_acc = 0; m_had = 0; m_tog = 0; m_wq = 0; m_rq = 0; m_vld = 0;
            m_poll = 0; m_last = 0; m_rdata = 0;
            foreach (m_arr[i]) m_arr[i] = 0;
            foreach (m_pv[i]) begin m_pv[i] = 0; m_pb[i] = 0; end
        end else begin
            w  = !ce_n && !we_n && guard_n;
            r  = !ce_n && !oe_n && we_n && guard_n;
            fa = w && !m_wq;
            ri = !w && m_wq;
            rs = r && !m_rq;
            if (rs) begin
                if (m_st != 0) begin
                    m_rdata = {~m_last[7], m_tog, 6'b0};
                    m_poll  = 1;
                    m_tog   = !m_tog;
                end else begin
                    m_rdata = m_arr[addr % 256];
                    m_poll  = 0;
                end
            end
            m_vld = r;
            case (m_st)
                0: if (fa) begin
                    m_st = 1; m_page = addr / 64; m_idx = addr % 64; m_acc = 1;
                    m_wc = 0; m_qc = 0; m_had = 0; m_tog = 1;
                    foreach (m_pv[i]) m_pv[i] = 0;
                end
                1: if (!guard_n) begin
                    m_st = 0;
                    foreach (m_pv[i]) m_pv[i] = 0;
                end else begin
                    if (fa) begin
                        if (m_wc < WIN) begin m_idx = addr % 64; m_acc = 1; m_wc = 0; end
                        else m_acc = 0;
                    end else if (m_wc < WIN) m_wc++;
                    if (ri && m_acc) begin
                        m_pb[m_idx] = wdata; m_pv[m_idx] = 1; m_last = wdata;
                        m_had = 1; m_acc = 0; m_qc = 0;
                    end else if (w) m_qc = 0;
                    else if (m_had) begin
                        if (m_qc == CLS - 1) begin m_st = 2; m_pc = 0; end
                        else m_qc++;
                    end
                end
                default: if (!guard_n) begin
                    m_st = 0;
                    foreach (m_pv[i]) m_pv[i] = 0;
                end else if (m_pc == PRG - 1) begin
                    for (int i = 0; i < 64; i++)
                        if (m_pv[i]) m_arr[(m_page % 4) * 64 + i] = m_pb[i];
                    foreach (m_pv[i]) m_pv[i] = 0;
                    m_st = 0;
                end else m_pc++;
            endcase
            m_wq = w;
            m_rq = r;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            ncmp++;
            if (rb_pull !== (m_st != 0)) begin
                nbad++;
                $display("FAIL R8 rb_pull got %0b exp %0b at %0t", rb_pull, (m_st != 0), $time);
            end
            ncmp++;
            if (rdata_vld !== m_vld) begin
                nbad++;
                $display("FAIL R10 rdata_vld got %0b exp %0b at %0t", rdata_vld, m_vld, $time);
            end
            if (m_vld) begin
                ncmp++;
                if (rdata !== m_rdata) begin
                    nbad++;
                    if (m_poll && rdata[7] !== m_rdata[7])
                        $display("FAIL R6 poll rdata got %h exp %h at %0t", rdata, m_rdata, $time);
                    else if (m_poll)
                        $display("FAIL R7 poll rdata got %h exp %h at %0t", rdata, m_rdata, $time);
                    else
                        $display("FAIL R3 rdata got %h exp %h at %0t", rdata, m_rdata, $time);
                end
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic chk(input string tag, input int got, input int exp);
        ncmp++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = 8'hEE; ce_n = 0; we_n = 0;
        @(negedge clk); addr = ~a; wdata = d;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1; wdata = 8'h00;
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; ce_n = 0; oe_n = 0; we_n = 1;
        @(negedge clk); d = rdata; chk("R10 vld", rdata_vld, 1);
        ce_n = 1; oe_n = 1;
        @(negedge clk);
    endtask

    task automatic wait_ready;
        for (int k = 0; k < 500 && rb_pull; k++) @(negedge clk);
        chk("R8 released", rb_pull, 0);
    endtask

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        chk("R8 reset", rb_pull, 0);
        chk("R10 reset", rdata_vld, 0);
        rd(13'h0005, v); chk("R3 reset array", v, 8'h00);

        // single byte write with polling
        wr(13'h0105, 8'hA5);
        chk("R8 busy after load", rb_pull, 1);
        rd(13'h0105, v); chk("R7 first poll", v, 8'h40);
        rd(13'h0105, v); chk("R7 second poll", v, 8'h00);
        wait_ready();
        rd(13'h0105, v); chk("R5 committed", v, 8'hA5);
        rd(13'h0005, v); chk("R3 alias", v, 8'hA5);
        rd(13'h0106, v); chk("R3 untouched", v, 8'h00);

        // page burst, last load with different page bits
        wr(13'h0080, 8'h10);
        rd(13'h0080, v); chk("R6 poll bit7", v, 8'hC0);
        wr(13'h0081, 8'h11);
        wr(13'h0082, 8'h12);
        wr(13'h0083, 8'h13);
        wr(13'h1FC7, 8'h77);
        wait_ready();
        rd(13'h0087, v); chk("R2 foreign page bits", v, 8'h77);
        rd(13'h1FC7, v); chk("R2 not in own page", v, 8'h00);
        rd(13'h0080, v); chk("R1 byte0", v, 8'h10);
        rd(13'h0083, v); chk("R1 byte3", v, 8'h13);
        rd(13'h0084, v); chk("R3 unloaded", v, 8'h00);
        rd(13'h0187, v); chk("R3 alias page", v, 8'h77);
        wr(13'h0080, 8'h99);
        wait_ready();
        rd(13'h0081, v); chk("R3 keep previous", v, 8'h11);
        rd(13'h0080, v); chk("R3 overwrite", v, 8'h99);

        // load outside the acceptance window
        wr(13'h00C0, 8'h31);
        idle(14);
        wr(13'h00C1, 8'h32);
        wait_ready();
        rd(13'h00C1, v); chk("R4 late load ignored", v, 8'h00);
        rd(13'h00C0, v); chk("R4 first load kept", v, 8'h31);

        // load during programming
        wr(13'h0040, 8'h01);
        idle(25);
        chk("R8 busy in programming", rb_pull, 1);
        wr(13'h0041, 8'h02);
        wait_ready();
        rd(13'h0041, v); chk("R5 load in programming ignored", v, 8'h00);
        rd(13'h0040, v); chk("R5 programmed", v, 8'h01);

        // guard during programming
        wr(13'h0060, 8'h55);
        idle(25);
        guard_n = 0;
        idle(2);
        chk("R9 abort releases", rb_pull, 0);
        @(negedge clk); ce_n = 0; oe_n = 0; addr = 13'h0060;
        @(negedge clk); chk("R9 read blocked", rdata_vld, 0);
        ce_n = 1; oe_n = 1;
        guard_n = 1;
        idle(2);
        rd(13'h0060, v); chk("R9 aborted program", v, 8'h00);

        // guard during loading
        wr(13'h0061, 8'h66);
        guard_n = 0;
        idle(2);
        guard_n = 1;
        idle(30);
        chk("R9 load abort idle", rb_pull, 0);
        rd(13'h0061, v); chk("R9 aborted load", v, 8'h00);

        // write attempt while guarded
        guard_n = 0;
        wr(13'h0062, 8'h77);
        chk("R9 no busy when guarded", rb_pull, 0);
        guard_n = 1;
        idle(5);
        rd(13'h0062, v); chk("R9 guarded write", v, 8'h00);

        // strobe formed by we_n first, ended by ce_n
        @(negedge clk); we_n = 0; addr = 13'h00A0; wdata = 8'h00;
        @(negedge clk); ce_n = 0;
        @(negedge clk); addr = 13'h1234; wdata = 8'h5A;
        @(negedge clk); ce_n = 1;
        @(negedge clk); we_n = 1; wdata = 8'h00;
        wait_ready();
        rd(13'h00A0, v); chk("R1 we-first strobe", v, 8'h5A);

        idle(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nbad++;
            $display("FAIL R5 watchdog expired, got running exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
            $finish;
        end
    end

endmodule